// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block is the hazard checker in the issue stage of an in-order pipeline. The stage feeds four classes of functional unit: integer, add, multiply and divide, and each class has its own fixed latency. Each cycle the stage presents at most one decoded operation: a class, a destination register and two source registers. The block answers in the same cycle whether that operation may dispatch. If it may not, a separate flag names each reason that holds.

The block keeps two pieces of state. One is a pending-write bit for every architectural register. The other is a reservation map of future cycles on the single result-write port. The functional units report whether they can take new work on a busy vector, and they report each completed result on a write-back notification port. Register 0 is a constant and never becomes pending. Because issue is in order, operands are always read before any younger write can happen, so the block has no write-after-read check.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset, every pending bit and every write-port reservation is clear. `issue_o` stays low while `in_valid` is low.
- R2: If the busy bit of the requested class is set (bit 0 integer, 1 add, 2 multiply, 3 divide, which is also the `in_cls` encoding), `stall_busy_o` is raised and the operation does not issue.
- R3: If either source register is pending at the start of the cycle, `stall_raw_o` is raised and the operation does not issue. A write-back that arrives in the same cycle does not lift this stall.
- R4: If the destination register is pending at the start of the cycle, `stall_waw_o` is raised and the operation does not issue.
- R5: An issued operation with a nonzero destination makes that register's pending bit read 1 from the next cycle.
- R6: A write-back notification clears the named register's pending bit from the next cycle.
- R7: If an issue sets a register and a write-back clears the same register in the same cycle, the bit reads 1 afterwards.
- R8: Latencies are integer 1, add 2, multiply 4, divide 6 cycles. The operation's write-back cycle is its latency counted from issue. If that cycle is already reserved, `stall_wbport_o` is raised and the operation does not issue.
- R9: `wb_slots_o` bit k shows that the result port is reserved k+1 cycles from now. On issue, the bit for the operation's latency is reserved, and the whole map moves down by one bit every cycle.
- R10: Register 0 never reads pending and never causes a RAW or WAW stall.
- R11: `issue_o` is high exactly when `in_valid` is high and no stall flag is raised. All stall flags are low when `in_valid` is low, and an invalid slot changes no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded operation is presented |
| in_cls | input | 2 | Unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| fu_busy | input | 4 | Per-class unit busy, indexed by class |
| wb_valid | input | 1 | A unit is writing back a result |
| wb_reg | input | 5 | Register written by that result |
| issue_o | output | 1 | Operation dispatches this cycle |
| stall_busy_o | output | 1 | Stall: requested unit busy |
| stall_raw_o | output | 1 | Stall: source pending |
| stall_waw_o | output | 1 | Stall: destination pending |
| stall_wbport_o | output | 1 | Stall: write-back cycle already reserved |
| pend_o | output | 32 | Pending-write bit per register |
| wb_slots_o | output | 6 | Write-port reservation map, bit k = k+1 cycles ahead |

## Verification
A pending bit that is wrongly left set shows up on the next cycle in two ways: as a spurious RAW or WAW flag on any operation that names that register, and as a bit on `pend_o`. A bit that is lost lets a dependent operation issue one cycle after the loss. A reservation that is misplaced or shifted at the wrong rate is visible on `wb_slots_o` on the next cycle. It appears at the stall outputs only when a later operation lands on the affected cycle, which is at most six cycles later. The stimulus walks reservations down to the integer slot so that such an error meets a colliding request.

// File: rtl/isb_pkg.sv
`timescale 1ns/1ps
package isb_pkg;

  localparam int unsigned NUM_CLS = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } fu_cls_e;

  // Latency of the selected class.
  function automatic int unsigned pick_lat(input logic [1:0] cls,
                                           input int unsigned l_int,
                                           input int unsigned l_add,
                                           input int unsigned l_mul,
                                           input int unsigned l_div);
    case (fu_cls_e'(cls))
      CLS_INT: return l_int;
      CLS_ADD: return l_add;
      CLS_MUL: return l_mul;
      default: return l_div;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/isb_pending.sv
`timescale 1ns/1ps
module isb_pending #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] pend
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign pend[r] = 1'b0;
    end else begin : g_bit
      logic hit_set, hit_clr, q;
      assign hit_set = set_en && (set_idx == REG_W'(r));
      assign hit_clr = clr_en && (clr_idx == REG_W'(r));
      always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (hit_set) q <= 1'b1;  // new writer wins over retiring one
        else if (hit_clr) q <= 1'b0;
      end
      assign pend[r] = q;
    end
  end

endmodule

// File: rtl/isb_wbslots.sv
`timescale 1ns/1ps
module isb_wbslots #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned LAT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [LAT_W-1:0] claim_lat,
  output logic [DEPTH-1:0] slots
);

  logic [DEPTH-1:0] claim_vec, slots_q;

  always_comb begin
    claim_vec = '0;
    for (int i = 0; i < int'(DEPTH); i++)
      claim_vec[i] = claim && (claim_lat == LAT_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slots_q <= '0;
    else        slots_q <= (slots_q | claim_vec) >> 1;
  end

  assign slots = slots_q;

endmodule

// File: rtl/isb_hazard.sv
`timescale 1ns/1ps
module isb_hazard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LAT_INT  = 1,
  parameter int unsigned LAT_ADD  = 2,
  parameter int unsigned LAT_MUL  = 4,
  parameter int unsigned LAT_DIV  = 6,
  localparam int unsigned REG_W   = $clog2(NUM_REGS),
  localparam int unsigned DEPTH   = isb_pkg::max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV),
  localparam int unsigned LAT_W   = $clog2(DEPTH + 1)
) (
  input  logic                         valid,
  input  logic [1:0]                   cls,
  input  logic [REG_W-1:0]             dst,
  input  logic [REG_W-1:0]             src1,
  input  logic [REG_W-1:0]             src2,
  input  logic [isb_pkg::NUM_CLS-1:0]  fu_busy,
  input  logic [NUM_REGS-1:0]          pend,
  input  logic [DEPTH-1:0]             slots,
  output logic [LAT_W-1:0]             lat,
  output logic                         st_busy,
  output logic                         st_raw,
  output logic                         st_waw,
  output logic                         st_port,
  output logic                         go
);

  logic slot_hit;

  always_comb begin
    lat = LAT_W'(isb_pkg::pick_lat(cls, LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV));
    slot_hit = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (lat == LAT_W'(i + 1)) slot_hit = slots[i];
  end

  assign st_busy = valid && fu_busy[cls];
  assign st_raw  = valid && (pend[src1] || pend[src2]);
  assign st_waw  = valid && pend[dst];
  assign st_port = valid && slot_hit;
  assign go      = valid && !(st_busy || st_raw || st_waw || st_port);

endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LAT_INT  = 1,
  parameter int unsigned LAT_ADD  = 2,
  parameter int unsigned LAT_MUL  = 4,
  parameter int unsigned LAT_DIV  = 6,
  localparam int unsigned REG_W   = $clog2(NUM_REGS),
  localparam int unsigned DEPTH   = isb_pkg::max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV),
  localparam int unsigned NCLS    = isb_pkg::NUM_CLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_cls,
  input  logic [REG_W-1:0]    in_dst,
  input  logic [REG_W-1:0]    in_src1,
  input  logic [REG_W-1:0]    in_src2,
  input  logic [NCLS-1:0]     fu_busy,
  input  logic                wb_valid,
  input  logic [REG_W-1:0]    wb_reg,
  output logic                issue_o,
  output logic                stall_busy_o,
  output logic                stall_raw_o,
  output logic                stall_waw_o,
  output logic                stall_wbport_o,
  output logic [NUM_REGS-1:0] pend_o,
  output logic [DEPTH-1:0]    wb_slots_o
);

  localparam int unsigned LAT_W = $clog2(DEPTH + 1);

  logic [NUM_REGS-1:0] pend;
  logic [DEPTH-1:0]    slots;
  logic [LAT_W-1:0]    op_lat;
  logic                go, mark_dst;

  isb_hazard #(
    .NUM_REGS(NUM_REGS), .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD),
    .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_haz (
    .valid(in_valid), .cls(in_cls), .dst(in_dst), .src1(in_src1), .src2(in_src2),
    .fu_busy(fu_busy), .pend(pend), .slots(slots), .lat(op_lat),
    .st_busy(stall_busy_o), .st_raw(stall_raw_o), .st_waw(stall_waw_o),
    .st_port(stall_wbport_o), .go(go)
  );

  assign mark_dst = go && (in_dst != '0);

  isb_pending #(.NUM_REGS(NUM_REGS)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(mark_dst), .set_idx(in_dst),
    .clr_en(wb_valid), .clr_idx(wb_reg),
    .pend(pend)
  );

  isb_wbslots #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_n), .claim(go), .claim_lat(op_lat), .slots(slots)
  );

  assign issue_o    = go;
  assign pend_o     = pend;
  assign wb_slots_o = slots;

endmodule

// File: rtl/isb_checker.sv
`timescale 1ns/1ps
module isb_checker #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DEPTH    = 6,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          in_cls,
  input logic [REG_W-1:0]    in_dst,
  input logic [REG_W-1:0]    in_src1,
  input logic [REG_W-1:0]    in_src2,
  input logic [3:0]          fu_busy,
  input logic                wb_valid,
  input logic [REG_W-1:0]    wb_reg,
  input logic                issue_o,
  input logic                stall_busy_o,
  input logic                stall_raw_o,
  input logic                stall_waw_o,
  input logic                stall_wbport_o,
  input logic [NUM_REGS-1:0] pend_o,
  input logic [DEPTH-1:0]    wb_slots_o
);

  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fu_busy[in_cls]) |-> !issue_o);

  a_r3_raw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pend_o[in_src1] || pend_o[in_src2])) |-> !issue_o);

  a_r4_waw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend_o[in_dst]) |-> !issue_o);

  a_r5_mark_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && in_dst != '0) |=> pend_o[$past(in_dst)]);

  a_r6_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(issue_o && in_dst == wb_reg)) |=> !pend_o[$past(wb_reg)]);

  a_r10_reg0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[0]);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !(issue_o || stall_busy_o || stall_raw_o || stall_waw_o || stall_wbport_o));

  a_r9_no_issue_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_o |=> wb_slots_o == ($past(wb_slots_o) >> 1));

endmodule

bind issue_scoreboard isb_checker #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_issue_scoreboard.sv
`timescale 1ns/1ps
module tb_issue_scoreboard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_cls = '0;
  logic [4:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [3:0]  fu_busy = '0;
  logic        wb_valid = 1'b0;
  logic [4:0]  wb_reg = '0;
  logic        issue_o, stall_busy_o, stall_raw_o, stall_waw_o, stall_wbport_o;
  logic [31:0] pend_o;
  logic [5:0]  wb_slots_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  issue_scoreboard dut (.*);

  // v cls dst s1 s2 busy wbv wbr | issue flags{busy,raw,waw,port} pend slots
  typedef struct packed {
    logic       v;   logic [1:0] cls; logic [4:0] dst; logic [4:0] s1; logic [4:0] s2;
    logic [3:0] bz;  logic wbv;       logic [4:0] wbr;
    logic       eiss; logic [3:0] eflg; logic [31:0] epend; logic [5:0] eslot;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 2'd2, 5'd3, 5'd1, 5'd2, 4'h0, 1'b0, 5'd0, 1'b1, 4'b0000, 32'h08, 6'h04}, // R5 R9 mul
    '{1'b1, 2'd1, 5'd4, 5'd3, 5'd0, 4'h0, 1'b0, 5'd0, 1'b0, 4'b0100, 32'h08, 6'h02}, // R3
    '{1'b1, 2'd0, 5'd3, 5'd1, 5'd1, 4'h0, 1'b0, 5'd0, 1'b0, 4'b0010, 32'h08, 6'h01}, // R4
    '{1'b1, 2'd0, 5'd5, 5'd1, 5'd2, 4'h0, 1'b0, 5'd0, 1'b0, 4'b0001, 32'h08, 6'h00}, // R8
    '{1'b1, 2'd0, 5'd5, 5'd1, 5'd2, 4'h0, 1'b1, 5'd3, 1'b1, 4'b0000, 32'h20, 6'h00}, // R6
    '{1'b1, 2'd1, 5'd6, 5'd3, 5'd5, 4'h2, 1'b0, 5'd0, 1'b0, 4'b1100, 32'h20, 6'h00}, // R2 R3
    '{1'b1, 2'd3, 5'd7, 5'd0, 5'd0, 4'h8, 1'b0, 5'd0, 1'b0, 4'b1000, 32'h20, 6'h00}, // R2
    '{1'b0, 2'd1, 5'd8, 5'd0, 5'd0, 4'h0, 1'b1, 5'd5, 1'b0, 4'b0000, 32'h00, 6'h00}, // R11 R6
    '{1'b1, 2'd1, 5'd6, 5'd3, 5'd5, 4'h0, 1'b0, 5'd0, 1'b1, 4'b0000, 32'h40, 6'h01}, // R9 add
    '{1'b1, 2'd0, 5'd0, 5'd0, 5'd0, 4'h0, 1'b0, 5'd0, 1'b0, 4'b0001, 32'h40, 6'h00}, // R8
    '{1'b1, 2'd3, 5'd0, 5'd6, 5'd0, 4'h0, 1'b0, 5'd0, 1'b0, 4'b0100, 32'h40, 6'h00}, // R3
    '{1'b1, 2'd3, 5'd0, 5'd0, 5'd0, 4'h0, 1'b0, 5'd0, 1'b1, 4'b0000, 32'h40, 6'h10}, // R10 div
    '{1'b1, 2'd0, 5'd6, 5'd0, 5'd0, 4'h0, 1'b1, 5'd6, 1'b0, 4'b0010, 32'h00, 6'h08}, // R3 R4
    '{1'b1, 2'd0, 5'd0, 5'd0, 5'd0, 4'h0, 1'b0, 5'd0, 1'b1, 4'b0000, 32'h00, 6'h04}  // R10
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    in_valid = r.v; in_cls = r.cls; in_dst = r.dst; in_src1 = r.s1; in_src2 = r.s2;
    fu_busy = r.bz; wb_valid = r.wbv; wb_reg = r.wbr;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    row_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 pend", 64'(pend_o), 64'h0);
    chk("R1 slots", 64'(wb_slots_o), 64'h0);
    chk("R1 idle issue", 64'(issue_o), 64'h0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      chk($sformatf("R11 issue row %0d", i), 64'(issue_o), 64'(TBL[i].eiss));
      chk($sformatf("R2 R3 R4 R8 flags row %0d", i),
          64'({stall_busy_o, stall_raw_o, stall_waw_o, stall_wbport_o}), 64'(TBL[i].eflg));
      @(posedge clk); #1;
      chk($sformatf("R5 R6 R10 pend row %0d", i), 64'(pend_o), 64'(TBL[i].epend));
      chk($sformatf("R9 slots row %0d", i), 64'(wb_slots_o), 64'(TBL[i].eslot));
    end

    // R7: set and clear of register 9 in one cycle leave it pending
    @(negedge clk);
    r = '0; r.v = 1'b1; r.cls = 2'd0; r.dst = 5'd9; r.wbv = 1'b1; r.wbr = 5'd9;
    drive(r); #1;
    chk("R7 issue", 64'(issue_o), 64'h1);
    @(posedge clk); #1;
    chk("R7 set wins", 64'(pend_o), 64'h200);

    // R6: a lone write-back then clears it
    @(negedge clk);
    r = '0; r.wbv = 1'b1; r.wbr = 5'd9;
    drive(r);
    @(posedge clk); #1;
    chk("R6 clear", 64'(pend_o), 64'h0);

    // R1: reset in mid-run wipes pending and reservations
    @(negedge clk);
    r = '0; r.v = 1'b1; r.cls = 2'd3; r.dst = 5'd12;
    drive(r);
    @(posedge clk); #1;
    chk("R5 div pend", 64'(pend_o), 64'h1000);
    chk("R9 div slot", 64'(wb_slots_o), 64'h10);
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset pend", 64'(pend_o), 64'h0);
    chk("R1 reset slots", 64'(wb_slots_o), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule